// File: doc/BRIEF.md
# Multi-Mode Gated Timer/Counter

A 32-bit timer/counter is driven by a small register interface. Software writes a control word, a reload value and, if it wishes, the count itself. The count advances on a tick taken from one of several sources: every system clock, the system clock divided by one of eight fixed ratios, or the carry output of a neighbouring instance. In event-counting mode the tick comes instead from rising edges on an external pin. In the two gated modes the counter only advances while a qualifier pin sits at the level software has chosen.

When a tick finds the count at its terminal value, the block does the following:

- It latches a sticky interrupt flag.
- It pulses a carry output, which can act as the tick source of the next instance so that instances chain into a wider counter.
- If software has enabled it, it pulses a terminal-count pin.
- If reload is enabled, it replaces the count with the stored reload value.

The terminal value is zero when counting down and all ones when counting up. The event and gate pins are asynchronous, so both pass through a two-flop synchronizer. An event source must therefore toggle at less than half the system clock rate.

Top module: `multi_mode_timer`

## Requirements
- R1: After reset the control word, reload value, count and interrupt flag read zero, and tc_o, carry_o and irq_o are low.
- R2: With tick source 0 (every clock) and mode 0 (free timer), an enabled counter changes by exactly one per clock: upward when direction bit 1 is 1, downward when it is 0.
- R3: Tick source codes 1 to 8 select the divisors 2, 4, 6, 16, 32, 62, 128 and 256 in that order. Enabled for n clocks from a cleared prescaler, the counter advances floor(n/D) times.
- R4: While enable bit 0 is 0, the count holds its value whatever the tick inputs do, and no terminal event occurs.
- R5: Mode 1 counts only while the synchronized gate is low. Mode 2 counts only while it is high. The mode sits in control bits 5:4.
- R6: Mode 3 adds exactly one count per rising edge of event_i and ignores the selected tick source.
- R7: A tick that finds the count at its terminal value (zero counting down, all ones counting up) sets the interrupt flag and gives a one-clock carry_o pulse in the following cycle.
- R8: On a terminal tick with reload bit 2 set, the count loads the reload register. With the bit clear, the count wraps around.
- R9: tc_o pulses together with carry_o only when tc-pin bit 3 is set. Otherwise tc_o stays low.
- R10: The interrupt flag (status bit 0, mirrored on irq_o) stays set until software writes 1 to status bit 0. Writing 0 to that bit leaves it unchanged.
- R11: Tick source code 9 takes one tick for each cycle in which cascade_i is high.
- R12: The register map is: address 0 is the control word in bits 9:0 (tick source in 9:6), address 1 is the reload value, address 2 is the count (writable), and address 3 is status. A write to address 2 takes effect in preference to a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| event_i | input | 1 | Asynchronous external event pin |
| gate_i | input | 1 | Asynchronous gate qualifier pin |
| cascade_i | input | 1 | Carry from the previous instance in a chain |
| tc_o | output | 1 | Terminal-count pin pulse |
| carry_o | output | 1 | Terminal-count carry pulse for chaining |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
The hardest case to reach from the ports is a terminal tick that lands in the same stretch as a reload, with the flag already set or just cleared. The full 32-bit range cannot be swept. The bench therefore writes the count directly to a few steps below the terminal value, then runs the counter for a known number of clocks in both directions, with and without reload. It counts tc_o and carry_o pulses against the expected number of wraps. The divisor table and both gate polarities are swept in full, with the expected tick counts computed from the clock count.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  typedef enum logic [1:0] {
    MODE_FREE    = 2'd0,
    MODE_GATE_LO = 2'd1,
    MODE_GATE_HI = 2'd2,
    MODE_EVENT   = 2'd3
  } mode_e;

  typedef struct packed {
    logic [3:0] src;
    mode_e      mode;
    logic       tc_pin;
    logic       reload;
    logic       up;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_COUNT  = 2'd2;
  localparam logic [1:0] ADDR_STAT   = 2'd3;

  localparam logic [3:0] SRC_CLK     = 4'd0;
  localparam logic [3:0] SRC_CASCADE = 4'd9;

  function automatic int unsigned div_of(input logic [3:0] sel);
    case (sel)
      4'd1:    return 2;
      4'd2:    return 4;
      4'd3:    return 6;
      4'd4:    return 16;
      4'd5:    return 32;
      4'd6:    return 62;
      4'd7:    return 128;
      4'd8:    return 256;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/mmt_sync.sv
module mmt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mmt_prescale.sv
module mmt_prescale #(
  parameter int PRE_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [3:0] sel_i,
  output logic       tick_o
);
  import mmt_pkg::*;

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] limit;

  assign limit  = PRE_W'(div_of(sel_i) - 1);
  assign tick_o = run_i && (cnt_q >= limit);

  // Cleared while stopped so every run starts on a fixed phase.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q >= limit) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mmt_count.sv
module mmt_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             up_i,
  input  logic             reload_en_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             term_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_term;

  assign at_term = up_i ? (&cnt_q) : (cnt_q == '0);
  assign term_o  = tick_i && at_term;
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (tick_i) begin
      if (at_term && reload_en_i)    cnt_q <= reload_val_i;
      else if (up_i)                 cnt_q <= cnt_q + 1'b1;
      else                           cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/multi_mode_timer.sv
module multi_mode_timer #(
  parameter int CNT_W       = 32,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  input  logic             event_i,
  input  logic             gate_i,
  input  logic             cascade_i,
  output logic             tc_o,
  output logic             carry_o,
  output logic             irq_o
);
  import mmt_pkg::*;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_q;
  logic             irq_q, tc_q, carry_q;
  logic             ev_s, gate_s, ev_d;
  logic             pre_tick, src_tick, tick, term;
  logic             wr_ctrl, wr_reload, wr_count, wr_stat;

  assign wr_ctrl   = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign wr_reload = reg_we_i && (reg_addr_i == ADDR_RELOAD);
  assign wr_count  = reg_we_i && (reg_addr_i == ADDR_COUNT);
  assign wr_stat   = reg_we_i && (reg_addr_i == ADDR_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
      if (wr_reload) reload_q <= reg_wdata_i;
    end
  end

  mmt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({event_i, gate_i}),
    .q_o   ({ev_s, gate_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ev_d <= 1'b0;
    else         ev_d <= ev_s;
  end

  mmt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (ctrl_q.en),
    .sel_i (ctrl_q.src),
    .tick_o(pre_tick)
  );

  always_comb begin
    if (ctrl_q.src == SRC_CLK)          src_tick = 1'b1;
    else if (ctrl_q.src == SRC_CASCADE) src_tick = cascade_i;
    else if (ctrl_q.src <= 4'd8)        src_tick = pre_tick;
    else                                src_tick = 1'b0;
  end

  always_comb begin
    case (ctrl_q.mode)
      MODE_GATE_LO: tick = src_tick && !gate_s;
      MODE_GATE_HI: tick = src_tick && gate_s;
      MODE_EVENT:   tick = ev_s && !ev_d;
      default:      tick = src_tick;
    endcase
    tick = tick && ctrl_q.en;
  end

  mmt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .up_i        (ctrl_q.up),
    .reload_en_i (ctrl_q.reload),
    .reload_val_i(reload_q),
    .load_i      (wr_count),
    .load_val_i  (reg_wdata_i),
    .count_o     (count_q),
    .term_o      (term)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b0;
      tc_q    <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      tc_q    <= term && ctrl_q.tc_pin;
      carry_q <= term;
      if (term)                           irq_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[0]) irq_q <= 1'b0;
    end
  end

  assign tc_o    = tc_q;
  assign carry_o = carry_q;
  assign irq_o   = irq_q;

  always_comb begin
    case (reg_addr_i)
      ADDR_CTRL:   reg_rdata_o = CNT_W'(ctrl_q);
      ADDR_RELOAD: reg_rdata_o = reload_q;
      ADDR_COUNT:  reg_rdata_o = count_q;
      default:     reg_rdata_o = CNT_W'(irq_q);
    endcase
  end
endmodule

// File: rtl/mmt_checker.sv
module mmt_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic [CNT_W-1:0] reg_wdata_i,
  input logic             ctrl_en,
  input logic             ctrl_tc_pin,
  input logic [CNT_W-1:0] count,
  input logic             tc_o,
  input logic             carry_o,
  input logic             irq_o
);
  logic clr_wr, cnt_wr;
  assign clr_wr = reg_we_i && (reg_addr_i == 2'd3) && reg_wdata_i[0];
  assign cnt_wr = reg_we_i && (reg_addr_i == 2'd2);

  assert_hold_disabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_en && !cnt_wr) |=> $stable(count));

  assert_carry_sets_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> irq_o);

  assert_irq_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> carry_o);

  assert_tc_with_carry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> carry_o);

  assert_tc_needs_pin_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> $past(ctrl_tc_pin));

  assert_irq_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_wr) |=> irq_o);
endmodule

bind multi_mode_timer mmt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .ctrl_en    (ctrl_q.en),
  .ctrl_tc_pin(ctrl_q.tc_pin),
  .count      (count_q),
  .tc_o       (tc_o),
  .carry_o    (carry_o),
  .irq_o      (irq_o)
);

// File: tb/sim_multi_mode_timer.sv
`timescale 1ns/1ps
module sim_multi_mode_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ev = 1'b0, gate = 1'b0, casc = 1'b0;
  logic        tc, carry, irq;
  int          n_chk = 0, n_fail = 0;
  int          tc_seen = 0, carry_seen = 0;

  always #2 clk = ~clk;

  multi_mode_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .event_i(ev), .gate_i(gate),
    .cascade_i(casc), .tc_o(tc), .carry_o(carry), .irq_o(irq)
  );

  always @(negedge clk) begin
    if (tc)    tc_seen++;
    if (carry) carry_seen++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic logic [31:0] cw(input int src, input int mode, input bit tcp,
                                     input bit rel, input bit up, input bit en);
    return 32'((src << 6) | (mode << 4) | (int'(tcp) << 3) | (int'(rel) << 2) | (int'(up) << 1) | int'(en));
  endfunction

  // enabled for exactly n clock edges
  task automatic run(input logic [31:0] c, input int n);
    wr(2'd0, c | 32'd1);
    repeat (n - 1) @(negedge clk);
    wr(2'd0, c & ~32'd1);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int t0, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", d, 0);
    rd(2'd1, d); check("R1 reload", d, 0);
    rd(2'd2, d); check("R1 count", d, 0);
    rd(2'd3, d); check("R1 status", d, 0);
    check("R1 pins", {29'd0, tc, carry, irq}, 0);

    // R12 register map readback
    wr(2'd0, 32'hFFFF_FFFE); rd(2'd0, d); check("R12 ctrl field", d, 32'h3FE);
    wr(2'd0, 0);
    wr(2'd1, 32'hA5A5_1234); rd(2'd1, d); check("R12 reload", d, 32'hA5A5_1234);

    // R2 every-clock source, both directions
    wr(2'd2, 0);   run(cw(0, 0, 0, 0, 1, 0), 10); rd(2'd2, d); check("R2 up", d, 10);
    wr(2'd2, 100); run(cw(0, 0, 0, 0, 0, 0), 7);  rd(2'd2, d); check("R2 down", d, 93);

    // R3 divisor sweep
    for (int s = 1; s <= 8; s++) begin
      int dv;
      case (s) 1: dv = 2; 2: dv = 4; 3: dv = 6; 4: dv = 16;
               5: dv = 32; 6: dv = 62; 7: dv = 128; default: dv = 256; endcase
      wr(2'd2, 0);
      run(cw(s, 0, 0, 0, 1, 0), 3 * dv + 1);
      rd(2'd2, d); check($sformatf("R3 div %0d", dv), d, 3);
    end

    // R4 disabled: ticks present but enable clear
    wr(2'd2, 50); wr(2'd0, cw(9, 0, 0, 0, 1, 0));
    casc = 1'b1; repeat (10) @(negedge clk);
    rd(2'd2, d); check("R4 hold", d, 50);
    // R11 cascade source
    run(cw(9, 0, 0, 0, 1, 0), 6); rd(2'd2, d); check("R11 cascade high", d, 56);
    casc = 1'b0;
    run(cw(9, 0, 0, 0, 1, 0), 6); rd(2'd2, d); check("R11 cascade low", d, 56);

    // R5 gate polarity sweep
    for (int m = 1; m <= 2; m++) begin
      for (int g = 0; g <= 1; g++) begin
        int exp_n;
        gate = g[0]; repeat (4) @(negedge clk);
        wr(2'd2, 0);
        run(cw(0, m, 0, 0, 1, 0), 9);
        exp_n = ((m == 1 && g == 0) || (m == 2 && g == 1)) ? 9 : 0;
        rd(2'd2, d); check($sformatf("R5 mode %0d gate %0d", m, g), d, exp_n);
      end
    end
    gate = 1'b0;

    // R6 event counting, source field ignored
    wr(2'd2, 0); wr(2'd0, cw(0, 3, 0, 0, 1, 1));
    for (int p = 0; p < 5; p++) begin
      ev = 1'b1; repeat (3) @(negedge clk);
      ev = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    wr(2'd0, 0); rd(2'd2, d); check("R6 events", d, 5);

    // R7 R8 R9 down count with reload and tc pin
    wr(2'd3, 1); rd(2'd3, d); check("R10 pre-clear", d, 0);
    wr(2'd1, 3); wr(2'd2, 3);
    t0 = tc_seen; c0 = carry_seen;
    run(cw(0, 0, 1, 1, 0, 0), 12);
    repeat (2) @(negedge clk);
    rd(2'd2, d); check("R8 reload value", d, 3);
    check("R9 tc pulses", tc_seen - t0, 3);
    check("R7 carry pulses", carry_seen - c0, 3);
    check("R7 irq set", {31'd0, irq}, 1);

    // R10 clear semantics
    wr(2'd3, 0); rd(2'd3, d); check("R10 write0 keeps", d, 1);
    wr(2'd3, 1); rd(2'd3, d); check("R10 write1 clears", d, 0);

    // R7 R8 R9 upward wrap without reload, tc pin off
    wr(2'd2, 32'hFFFF_FFFD);
    t0 = tc_seen; c0 = carry_seen;
    run(cw(0, 0, 0, 0, 1, 0), 3);
    repeat (2) @(negedge clk);
    rd(2'd2, d); check("R8 wrap", d, 0);
    check("R9 tc suppressed", tc_seen - t0, 0);
    check("R7 up carry", carry_seen - c0, 1);
    check("R7 up irq", {31'd0, irq}, 1);

    // R12 count write beats tick
    wr(2'd0, cw(0, 0, 0, 0, 1, 1));
    wr(2'd2, 32'd500);
    wr(2'd0, 0);
    rd(2'd2, d); check("R12 write priority", d, 501);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule